// File: doc/BRIEF.md
# DRAM ECC Error Logging Registers

This block sits beside a two-channel DRAM controller and keeps a record of the error events that the controller reports. Correctable and uncorrectable ECC errors arrive as single-cycle pulses. Each error kind has its own context bus: a 33-bit physical address, a channel bit and an 8-bit syndrome. Three more event pulses report a refresh timeout, a locked access to memory that is not DRAM, and a thermal sensor trip. Every event sets a sticky flag in a 16-bit status register. A 16-bit command register, which uses the same bit positions, chooses which flagged events drive the SERR level output.

Software reaches the registers over a simple byte-wide register bus with read, write and an 8-bit byte address. Read data is combinational. Status flags clear when software writes 1 to them. For one ECC error the block keeps the context: the address at 128-byte grain, the channel and the syndrome. An uncorrectable error displaces the context of a correctable error that is still pending. While an uncorrectable error is pending, the context is held.

Top module: `dram_err_log`

## Requirements
- R1: After reset, every mapped byte (0x00 to 0x09) reads 0, unmapped bytes read 0, and `serr` is low.
- R2: The status register spans bytes 0x00 (bits 7:0) and 0x01 (bits 15:8). A correctable pulse sets bit 0, an uncorrectable pulse sets bit 1, a refresh timeout sets bit 8, a non-DRAM lock sets bit 9 and a thermal event sets bit 11. Flags stay set until cleared. All other bits read 0.
- R3: Writing a status byte clears each event bit written as 1 and leaves each bit written as 0 unchanged. An event arriving in the same cycle as its clear leaves the flag set.
- R4: The command register spans bytes 0x02 (bits 7:0) and 0x03 (bits 15:8) and is read/write. Only bits 0, 1, 8, 9 and 11 are stored. The other bits read 0.
- R5: `serr` is high exactly when some event bit is set in both the status and the command register.
- R6: Bytes 0x04 to 0x07 form a 32-bit error address word, least significant byte at 0x04. Its bits 31:7 hold address bits 31:7, bit 0 holds the channel, and bits 6:1 read 0. Byte 0x08 bit 0 holds address bit 32, with bits 7:1 reading 0. Byte 0x09 holds the syndrome.
- R7: An ECC error arriving when neither ECC flag is left set (after any same-cycle clear) captures its own address, channel and syndrome.
- R8: An uncorrectable error arriving while only the correctable flag is set overwrites the captured context with its own values and sets bit 1. Bit 0 stays set.
- R9: A correctable error arriving while any ECC flag is set, or an uncorrectable error arriving while bit 1 is set, leaves the captured context unchanged.
- R10: When correctable and uncorrectable pulses coincide with no ECC flag set, the uncorrectable context is captured and both flags are set.
- R11: Writes to bytes 0x04 to 0x09 and to unmapped bytes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_pulse | input | 1 | Correctable error event |
| ce_addr | input | 33 | Physical address of correctable error |
| ce_chan | input | 1 | Channel of correctable error |
| ce_syn | input | 8 | Syndrome of correctable error |
| ue_pulse | input | 1 | Uncorrectable error event |
| ue_addr | input | 33 | Physical address of uncorrectable error |
| ue_chan | input | 1 | Channel of uncorrectable error |
| ue_syn | input | 8 | Syndrome of uncorrectable error |
| refresh_to | input | 1 | Refresh timeout event |
| lock_nondram | input | 1 | Locked access to non-DRAM memory event |
| thermal_evt | input | 1 | Thermal sensor event |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| serr | output | 1 | System error level |

## Verification
The bench aims at the ordering corners of context capture.

- A correctable error followed by a second correctable error must keep the first context. A design that recaptured would report the wrong address.
- An uncorrectable error after a correctable one must replace the context. A design that held the context would attach the correctable address to a fatal error.
- A second uncorrectable error must not replace the first.
- Coincident correctable and uncorrectable pulses must capture the uncorrectable context.
- A clear in the same cycle as a new error must keep the flag and capture the new context. A design that let the clear win would lose the event.

The bench also sweeps all 32 status patterns against all 32 command patterns to check SERR gating, checks partial write-1 clears, and checks that writes to the read-only context bytes are ignored.

// File: rtl/dram_err_log.sv
module dram_err_log #(
  parameter int PA_W = 33,
  parameter int SYN_W = 8,
  parameter int BA_W = 8,
  parameter int GRAIN_LG = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_pulse,
  input  logic [PA_W-1:0]  ce_addr,
  input  logic             ce_chan,
  input  logic [SYN_W-1:0] ce_syn,
  input  logic             ue_pulse,
  input  logic [PA_W-1:0]  ue_addr,
  input  logic             ue_chan,
  input  logic [SYN_W-1:0] ue_syn,
  input  logic             refresh_to,
  input  logic             lock_nondram,
  input  logic             thermal_evt,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [BA_W-1:0]  bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             serr
);
  localparam logic [15:0] EV_MASK = 16'h0B03;
  localparam int HI_W = 32 - GRAIN_LG;

  logic [15:0] sts_q, cmd_q;
  logic [HI_W-1:0] ea_q;
  logic ch_q, ex_q;
  logic [SYN_W-1:0] syn_q;

  wire wr_s0 = bus_wr && bus_addr == BA_W'(0);
  wire wr_s1 = bus_wr && bus_addr == BA_W'(1);
  wire wr_c0 = bus_wr && bus_addr == BA_W'(2);
  wire wr_c1 = bus_wr && bus_addr == BA_W'(3);

  wire [15:0] clr = {wr_s1 ? bus_wdata : 8'h00, wr_s0 ? bus_wdata : 8'h00} & EV_MASK;
  wire [15:0] evs = {4'b0, thermal_evt, 1'b0, lock_nondram, refresh_to, 6'b0, ue_pulse, ce_pulse};
  wire [15:0] left = sts_q & ~clr;

  wire cap_ue = ue_pulse && !left[1];
  wire cap_ce = ce_pulse && !left[0] && !left[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
      cmd_q <= '0;
      ea_q  <= '0;
      ch_q  <= 1'b0;
      ex_q  <= 1'b0;
      syn_q <= '0;
    end else begin
      sts_q <= left | evs;
      if (wr_c0) cmd_q[7:0]  <= bus_wdata & EV_MASK[7:0];
      if (wr_c1) cmd_q[15:8] <= bus_wdata & EV_MASK[15:8];
      if (cap_ue) begin
        ea_q  <= ue_addr[31:GRAIN_LG];
        ex_q  <= ue_addr[32];
        ch_q  <= ue_chan;
        syn_q <= ue_syn;
      end else if (cap_ce) begin
        ea_q  <= ce_addr[31:GRAIN_LG];
        ex_q  <= ce_addr[32];
        ch_q  <= ce_chan;
        syn_q <= ce_syn;
      end
    end
  end

  wire [31:0] addr_word = {ea_q, {(GRAIN_LG-1){1'b0}}, ch_q};

  always_comb begin
    case (bus_addr)
      BA_W'(0): bus_rdata = sts_q[7:0];
      BA_W'(1): bus_rdata = sts_q[15:8];
      BA_W'(2): bus_rdata = cmd_q[7:0];
      BA_W'(3): bus_rdata = cmd_q[15:8];
      BA_W'(4): bus_rdata = addr_word[7:0];
      BA_W'(5): bus_rdata = addr_word[15:8];
      BA_W'(6): bus_rdata = addr_word[23:16];
      BA_W'(7): bus_rdata = addr_word[31:24];
      BA_W'(8): bus_rdata = {7'b0, ex_q};
      BA_W'(9): bus_rdata = syn_q;
      default:  bus_rdata = 8'h00;
    endcase
  end

  assign serr = |(sts_q & cmd_q);

  wire unused_ok = bus_rd;

  p_ce_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ce_pulse |=> sts_q[0]);

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_s0 && bus_wdata[1] && !ue_pulse) |=> !sts_q[1]);

  p_overwrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_pulse && !sts_q[1]) |=> (ea_q == $past(ue_addr[31:GRAIN_LG]) && syn_q == $past(ue_syn)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[1] && !wr_s0) |=> ($stable(ea_q) && $stable(syn_q) && $stable(ch_q)));

  p_serr_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == 16'h0) |-> !serr);
endmodule

// File: tb/dram_err_log_tb_top.sv
module dram_err_log_tb_top;
  logic clk = 0, rst_n = 0;
  logic ce_pulse = 0, ue_pulse = 0, ce_chan = 0, ue_chan = 0;
  logic [32:0] ce_addr = '0, ue_addr = '0;
  logic [7:0] ce_syn = '0, ue_syn = '0;
  logic refresh_to = 0, lock_nondram = 0, thermal_evt = 0;
  logic bus_rd = 0, bus_wr = 0;
  logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic serr;
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [15:0] MSK = 16'h0B03;
  logic [15:0] m_sts = 0, m_cmd = 0;
  logic [32:0] m_addr = 0;
  logic m_ch = 0;
  logic [7:0] m_syn = 0;

  always #10 clk = ~clk;

  dram_err_log dut_i (.clk(clk), .rst_n(rst_n), .ce_pulse(ce_pulse), .ce_addr(ce_addr),
    .ce_chan(ce_chan), .ce_syn(ce_syn), .ue_pulse(ue_pulse), .ue_addr(ue_addr),
    .ue_chan(ue_chan), .ue_syn(ue_syn), .refresh_to(refresh_to), .lock_nondram(lock_nondram),
    .thermal_evt(thermal_evt), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .serr(serr));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(string req, logic [7:0] a, logic [7:0] exp);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    #1 chk(req, bus_rdata, exp);
    bus_rd = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    case (a)
      0: m_sts = m_sts & ~({8'h0, d} & MSK);
      1: m_sts = m_sts & ~({d, 8'h0} & MSK);
      2: m_cmd[7:0] = d & MSK[7:0];
      3: m_cmd[15:8] = d & MSK[15:8];
      default: ;
    endcase
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic step(bit ce, bit ue, logic [32:0] ca, bit cc, logic [7:0] cs,
                      logic [32:0] ua, bit uc, logic [7:0] us,
                      bit rf, bit lk, bit th, bit clr_en, logic [7:0] clr);
    logic [15:0] left;
    @(negedge clk);
    ce_pulse = ce; ue_pulse = ue; ce_addr = ca; ce_chan = cc; ce_syn = cs;
    ue_addr = ua; ue_chan = uc; ue_syn = us;
    refresh_to = rf; lock_nondram = lk; thermal_evt = th;
    bus_wr = clr_en; bus_addr = 0; bus_wdata = clr;
    left = m_sts & ~((clr_en ? {8'h0, clr} : 16'h0) & MSK);
    if (ue && !left[1]) begin m_addr = ua; m_ch = uc; m_syn = us; end
    else if (ce && !left[0] && !left[1]) begin m_addr = ca; m_ch = cc; m_syn = cs; end
    m_sts = left | {4'b0, th, 1'b0, lk, rf, 6'b0, ue, ce};
    @(negedge clk);
    ce_pulse = 0; ue_pulse = 0; refresh_to = 0; lock_nondram = 0; thermal_evt = 0; bus_wr = 0;
  endtask

  task automatic ctx(string req);
    logic [31:0] w;
    w = {m_addr[31:7], 6'b0, m_ch};
    rd(req, 0, m_sts[7:0]);
    rd(req, 1, m_sts[15:8]);
    for (int i = 0; i < 4; i++) rd(req, 8'(4 + i), w[8*i +: 8]);
    rd(req, 8, {7'b0, m_addr[32]});
    rd(req, 9, m_syn);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 16; a++) rd("R1 reset", 8'(a), 8'h00);
    #1 chk("R1 serr", serr, 0);

    step(1,0, 33'h1_2345_6789,1,8'hA5, 0,0,0, 0,0,0, 0,0);
    ctx("R7 first CE captured");
    step(1,0, 33'h0_0BAD_F00D,0,8'h11, 0,0,0, 0,0,0, 0,0);
    ctx("R9 second CE held");
    step(0,1, 0,0,0, 33'h0_DEAD_BEEF,1,8'h3C, 0,0,0, 0,0);
    ctx("R8 UE overwrites CE");
    step(0,1, 0,0,0, 33'h1_FFFF_FFFF,0,8'h77, 0,0,0, 0,0);
    ctx("R9 second UE held");
    step(1,0, 33'h0_1111_1111,0,8'h22, 0,0,0, 0,0,0, 0,0);
    ctx("R9 CE during UE held");
    wr(0, 8'h01);
    ctx("R3 partial clear keeps UE flag");
    wr(0, 8'h00);
    ctx("R3 zero write no change");
    wr(0, 8'h02);
    ctx("R3 UE clear");
    step(1,0, 33'h1_0000_0080,1,8'h5A, 0,0,0, 0,0,0, 0,0);
    ctx("R7 fresh capture after clear R6");
    wr(0, 8'h03);
    step(1,1, 33'h0_AAAA_AA80,0,8'h01, 33'h1_5555_5500,1,8'hFE, 0,0,0, 0,0);
    ctx("R10 simultaneous UE wins");
    step(1,0, 33'h0_CAFE_0000,1,8'h99, 0,0,0, 0,0,0, 1,8'h03);
    ctx("R3 R7 clear with same-cycle CE");
    step(0,0, 0,0,0, 0,0,0, 1,1,1, 0,0);
    for (int a = 4; a < 16; a++) wr(8'(a), 8'hFF);
    ctx("R11 context writes ignored R2");
    wr(2, 8'hFF); wr(3, 8'hFF);
    rd("R4 cmd lo", 2, 8'h03);
    rd("R4 cmd hi", 3, 8'h0B);
    wr(0, 8'hFF); wr(1, 8'hFF);
    ctx("R3 clear all");

    for (int s = 0; s < 32; s++) begin
      wr(0, 8'hFF); wr(1, 8'hFF);
      step(s[0], s[1], 33'h0_0000_1000,0,8'h10, 33'h0_0000_2000,0,8'h20,
           s[2], s[3], s[4], 0, 0);
      rd("R2 status lo", 0, m_sts[7:0]);
      rd("R2 status hi", 1, m_sts[15:8]);
      for (int c = 0; c < 32; c++) begin
        wr(2, {6'b0, c[1], c[0]});
        wr(3, {4'b0, c[4], 1'b0, c[3], c[2]});
        #1 chk("R5 serr gating", serr, |(m_sts & m_cmd));
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule